// File: doc/BRIEF.md
# Streaming Pixel Format Packer

This block takes a stream of pixels, one per cycle, each carried as four 8-bit channels (red, green, blue, alpha). It packs them into 32-bit memory words for a frame writer. A 4-bit layout code sets both the bit depth and the channel order. The supported families are 16-bit 4:4:4:4, 16-bit 5:6:5, 24-bit 8:8:8 and 32-bit 8:8:8:8. Each output word carries a 4-bit lane strobe that tells the memory side which bytes to write.

The alpha field is handled in one of three ways: it is stored from the input, it is stored bit-inverted, or it is replaced by a constant fill. A 4-bit lane mask can suppress writes to chosen byte lanes of every word. Pixels of 24 bits cross word boundaries freely. An end-of-line marker on the last pixel of a line forces out any partly filled word. Both the pixel input and the word output use a valid/ready handshake. An unsupported layout code discards pixels and raises a sticky error flag.

Top module: `pix_pack_top`

## Requirements
- R1: In the 32-bit layouts (codes 12 ABGR, 13 ARGB, 14 BGRA, 15 RGBA, channels named from byte 3 down to byte 0), each accepted pixel produces one word with the channels in the byte lanes its code names.
- R2: In the 4:4:4:4 layouts (codes 0 ABGR, 1 ARGB, 2 BGRA, 3 RGBA, named from bits 15:12 down to 3:0), each channel keeps its upper 4 bits, and two pixels fill a word, the earlier one in bits 15:0.
- R3: In the 5:6:5 layouts (code 6 BGR, code 7 RGB, first-named channel in bits 15:11), the outer channels keep their upper 5 bits and green keeps its upper 6 bits in bits 10:5, with no rounding. Two pixels fill a word, the earlier one in the low half.
- R4: In the 24-bit layouts (code 8 BGR, code 9 RGB, first-named channel in the highest of the three bytes), pixels form a continuous byte stream, lowest byte first, that fills words from lane 0 upward and crosses word boundaries.
- R5: With alpha storing on, the alpha field holds the input alpha, or its bitwise inverse when the invert control is set. In 4:4:4:4 this is the upper nibble of that value.
- R6: With alpha storing off, every bit of the alpha field equals the complement of the invert control.
- R7: The strobe bit of byte lane i of every output word is forced low when bit i of the lane-mask control is low. The data bytes are unaffected.
- R8: A pixel marked end-of-line sends out any partial word that remains. That word has strobes only on the lanes holding pixel bytes, its unused lanes are zero, and it may follow a full word from the same pixel.
- R9: A pixel presented with codes 4, 5, 10 or 11 is accepted but produces no output word. It sets an error flag that stays set until reset.
- R10: While the output is valid and not taken, the word and its strobes hold unchanged.
- R11: After reset the output is not valid, the error flag is low and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 4 | Layout code |
| cfg_alpha_en | input | 1 | Store alpha from input (1) or fill (0) |
| cfg_alpha_inv | input | 1 | Invert stored alpha, or choose fill value |
| cfg_lane_en | input | 4 | Per-lane write mask |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when valid |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| in_eol | input | 1 | Last pixel of the line |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Word taken this cycle when valid |
| out_data | output | 32 | Packed word |
| out_be | output | 4 | Lane write strobes |
| fmt_err | output | 1 | Sticky unsupported-layout flag |

## Verification
The assertions assume that the configuration inputs stay constant while pixels or words are in flight. In particular, the lane-strobe check compares the output strobes against the current lane mask, so it holds only if that mask is unchanged from acceptance to delivery. The stimulus changes configuration only between lines: each line ends with an end-of-line pixel, and the bench then waits until every expected word has drained before it writes new settings. Backpressure on the output comes from a pseudo-random pattern that the bench updates on the clock edge, so the ready signal is steady whenever the driver and monitor sample it.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = LANES * BYTE_W;
  localparam int CNT_W   = $clog2(2 * LANES);

  typedef struct packed {
    logic             ok;
    logic [CNT_W-1:0] nbytes;
  } fmt_info_t;

  function automatic fmt_info_t fmt_decode(input logic [3:0] code);
    fmt_info_t f;
    f.ok     = 1'b1;
    f.nbytes = CNT_W'(2);
    unique case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7: f.nbytes = CNT_W'(2);
      4'd8, 4'd9:                         f.nbytes = CNT_W'(3);
      4'd12, 4'd13, 4'd14, 4'd15:         f.nbytes = CNT_W'(4);
      default: begin
        f.ok     = 1'b0;
        f.nbytes = '0;
      end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/pxpk_encode.sv
module pxpk_encode
  import pxpk_pkg::*;
(
  input  logic [3:0]        fmt,
  input  logic              alpha_en,
  input  logic              alpha_inv,
  input  logic [BYTE_W-1:0] r,
  input  logic [BYTE_W-1:0] g,
  input  logic [BYTE_W-1:0] b,
  input  logic [BYTE_W-1:0] a,
  output logic [WORD_W-1:0] bytes_o
);
  logic [BYTE_W-1:0] av, hi, lo;

  always_comb begin
    av = alpha_en ? (alpha_inv ? ~a : a) : {BYTE_W{~alpha_inv}};
    hi = fmt[0] ? r : b;
    lo = fmt[0] ? b : r;
    bytes_o = '0;
    unique case (fmt[3:2])
      2'b00: bytes_o[15:0] = fmt[1] ?
               {hi[7:4], g[7:4], lo[7:4], av[7:4]} :
               {av[7:4], hi[7:4], g[7:4], lo[7:4]};
      2'b01: bytes_o[15:0] = {hi[7:3], g[7:2], lo[7:3]};
      2'b10: bytes_o[23:0] = {hi, g, lo};
      default: bytes_o = fmt[1] ? {hi, g, lo, av} : {av, hi, g, lo};
    endcase
  end
endmodule

// File: rtl/pxpk_packer.sv
module pxpk_packer
  import pxpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_vld,
  input  logic [WORD_W-1:0] pix_bytes,
  input  logic [CNT_W-1:0]  pix_n,
  input  logic              pix_eol,
  input  logic [LANES-1:0]  lane_en,
  output logic              take_ok,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_be
);
  localparam int ACC_W = 2 * WORD_W;

  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  fill;
  logic              flush_pend;
  logic              slot_free;
  logic [ACC_W-1:0]  merged;
  logic [CNT_W-1:0]  total;

  function automatic logic [LANES-1:0] lane_mask(input logic [CNT_W-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  assign slot_free = !out_valid || out_ready;
  assign take_ok   = slot_free && !flush_pend;
  assign merged    = {{WORD_W{1'b0}}, acc} |
                     ({{WORD_W{1'b0}}, pix_bytes} << (32'(fill) << 3));
  assign total     = fill + pix_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      fill       <= '0;
      flush_pend <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_be     <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush_pend && slot_free) begin
        out_valid  <= 1'b1;
        out_data   <= acc;
        out_be     <= lane_mask(fill) & lane_en;
        acc        <= '0;
        fill       <= '0;
        flush_pend <= 1'b0;
      end else if (pix_vld && take_ok) begin
        if (int'(total) >= LANES) begin
          out_valid  <= 1'b1;
          out_data   <= merged[WORD_W-1:0];
          out_be     <= lane_en;
          acc        <= merged[ACC_W-1:WORD_W];
          fill       <= total - CNT_W'(LANES);
          flush_pend <= pix_eol && (int'(total) != LANES);
        end else if (pix_eol && total != '0) begin
          out_valid <= 1'b1;
          out_data  <= merged[WORD_W-1:0];
          out_be    <= lane_mask(total) & lane_en;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= merged[WORD_W-1:0];
          fill <= total;
        end
      end
    end
  end
endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
  import pxpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cfg_fmt,
  input  logic              cfg_alpha_en,
  input  logic              cfg_alpha_inv,
  input  logic [LANES-1:0]  cfg_lane_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_r,
  input  logic [BYTE_W-1:0] in_g,
  input  logic [BYTE_W-1:0] in_b,
  input  logic [BYTE_W-1:0] in_a,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_be,
  output logic              fmt_err
);
  fmt_info_t         info;
  logic [WORD_W-1:0] enc;

  assign info = fmt_decode(cfg_fmt);

  pxpk_encode u_enc (
    .fmt       (cfg_fmt),
    .alpha_en  (cfg_alpha_en),
    .alpha_inv (cfg_alpha_inv),
    .r         (in_r),
    .g         (in_g),
    .b         (in_b),
    .a         (in_a),
    .bytes_o   (enc)
  );

  pxpk_packer u_pack (
    .clk       (clk),
    .rst       (rst),
    .pix_vld   (in_valid && info.ok),
    .pix_bytes (enc),
    .pix_n     (info.nbytes),
    .pix_eol   (in_eol),
    .lane_en   (cfg_lane_en),
    .take_ok   (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_be    (out_be)
  );

  always_ff @(posedge clk) begin
    if (rst) fmt_err <= 1'b0;
    else if (in_valid && in_ready && !info.ok) fmt_err <= 1'b1;
  end
endmodule

// File: rtl/pxpk_checker.sv
module pxpk_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  cfg_fmt,
  input logic [3:0]  cfg_lane_en,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_be,
  input logic        fmt_err
);
  logic bad_code;
  assign bad_code = (cfg_fmt == 4'd4) || (cfg_fmt == 4'd5) ||
                    (cfg_fmt == 4'd10) || (cfg_fmt == 4'd11);

  AST_LANE_GATED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_be & ~cfg_lane_en) == 4'h0)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be))); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err); // R9

  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && bad_code) |=> fmt_err); // R9

  AST_STROBE_CONTIG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_lane_en == 4'hF) |->
      (out_be == 4'h1 || out_be == 4'h3 || out_be == 4'h7 || out_be == 4'hF)); // R8
endmodule

bind pix_pack_top pxpk_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_fmt     (cfg_fmt),
  .cfg_lane_en (cfg_lane_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_be      (out_be),
  .fmt_err     (fmt_err)
);

// File: tb/tb_pix_pack_top.sv
module tb_pix_pack_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cfg_fmt;
  logic        cfg_alpha_en, cfg_alpha_inv;
  logic [3:0]  cfg_lane_en;
  logic        in_valid, in_ready, in_eol;
  logic [7:0]  in_r, in_g, in_b, in_a;
  logic        out_valid, out_ready, fmt_err;
  logic [31:0] out_data;
  logic [3:0]  out_be;

  logic [15:0] lfsr = 16'hACE1;
  logic        bp_on = 1'b0;
  assign out_ready = !bp_on || lfsr[0];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  pix_pack_top dut (.*);

  typedef struct { logic [31:0] d; logic [3:0] be; string tag; } item_t;
  item_t      expq[$];
  logic [7:0] bq[$];
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  string      cur_tag = "R1";

  function automatic logic [7:0] av_f(logic [7:0] a);
    if (cfg_alpha_en) return cfg_alpha_inv ? ~a : a;
    return cfg_alpha_inv ? 8'h00 : 8'hFF;
  endfunction

  task automatic emit(int n);
    item_t it;
    it.d = '0; it.be = '0; it.tag = cur_tag;
    for (int i = 0; i < n; i++) begin
      it.d[8*i +: 8] = bq.pop_front();
      it.be[i] = cfg_lane_en[i];
    end
    expq.push_back(it);
  endtask

  task automatic model(logic [7:0] r, g, b, a, logic eol);
    logic [31:0] w; int n; logic [7:0] x;
    x = av_f(a); w = '0; n = 0;
    case (cfg_fmt)
      4'd0:  begin w = {16'h0, x[7:4], b[7:4], g[7:4], r[7:4]}; n = 2; end
      4'd1:  begin w = {16'h0, x[7:4], r[7:4], g[7:4], b[7:4]}; n = 2; end
      4'd2:  begin w = {16'h0, b[7:4], g[7:4], r[7:4], x[7:4]}; n = 2; end
      4'd3:  begin w = {16'h0, r[7:4], g[7:4], b[7:4], x[7:4]}; n = 2; end
      4'd6:  begin w = {16'h0, b[7:3], g[7:2], r[7:3]}; n = 2; end
      4'd7:  begin w = {16'h0, r[7:3], g[7:2], b[7:3]}; n = 2; end
      4'd8:  begin w = {8'h0, b, g, r}; n = 3; end
      4'd9:  begin w = {8'h0, r, g, b}; n = 3; end
      4'd12: begin w = {x, b, g, r}; n = 4; end
      4'd13: begin w = {x, r, g, b}; n = 4; end
      4'd14: begin w = {b, g, r, x}; n = 4; end
      4'd15: begin w = {r, g, b, x}; n = 4; end
      default: n = 0;
    endcase
    for (int i = 0; i < n; i++) bq.push_back(w[8*i +: 8]);
    while (bq.size() >= 4) emit(4);
    if (eol && bq.size() > 0) emit(bq.size());
  endtask

  task automatic send(logic [7:0] r, g, b, a, logic eol);
    @(negedge clk);
    in_valid = 1'b1; in_r = r; in_g = g; in_b = b; in_a = a; in_eol = eol;
    while (!in_ready) @(negedge clk);
    model(r, g, b, a, eol);
  endtask

  task automatic line(int n, int seed);
    for (int i = 0; i < n; i++)
      send(8'(seed * 37 + i * 91), 8'(seed * 11 + i * 53 + 7),
           8'(seed * 73 + i * 29 + 3), 8'(seed * 5 + i * 17 + 200), i == n - 1);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0;
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setcfg(logic [3:0] f, logic ae, logic ai, logic [3:0] le, string tag);
    cfg_fmt = f; cfg_alpha_en = ae; cfg_alpha_inv = ai; cfg_lane_en = le; cur_tag = tag;
  endtask

  logic        stall_seen = 1'b0;
  logic [31:0] stall_d;
  logic [3:0]  stall_be;

  always @(negedge clk) begin
    if (!rst) begin
      if (stall_seen) begin
        check("R10 hold valid", 32'(out_valid), 32'h1);
        check("R10 hold data", out_data, stall_d);
        check("R10 hold be", 32'(out_be), 32'(stall_be));
      end
      stall_seen = out_valid && !out_ready;
      stall_d = out_data; stall_be = out_be;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check({cur_tag, " unexpected word"}, out_data, 32'hxxxxxxxx);
        end else begin
          item_t it;
          it = expq.pop_front();
          check({it.tag, " data"}, out_data, it.d);
          check({it.tag, " be"}, 32'(out_be), 32'(it.be));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_eol = 1'b0;
    in_r = '0; in_g = '0; in_b = '0; in_a = '0;
    setcfg(4'd13, 1'b1, 1'b0, 4'hF, "R1");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 out_valid", 32'(out_valid), 0);
    check("R11 fmt_err", 32'(fmt_err), 0);
    check("R11 in_ready", 32'(in_ready), 1);

    for (int f = 12; f <= 15; f++) begin setcfg(4'(f), 1, 0, 4'hF, "R1"); line(3, f); drain(); end
    for (int f = 0; f <= 3; f++) begin setcfg(4'(f), 1, 0, 4'hF, "R2"); line(4, f); drain(); end
    setcfg(4'd6, 1, 0, 4'hF, "R3"); line(6, 2); drain();
    setcfg(4'd7, 1, 0, 4'hF, "R3"); line(4, 9); drain();
    setcfg(4'd9, 1, 0, 4'hF, "R4"); line(8, 4); drain();
    setcfg(4'd8, 1, 0, 4'hF, "R4"); line(4, 6); drain();

    setcfg(4'd13, 1, 1, 4'hF, "R5"); line(3, 7); drain();
    setcfg(4'd3,  1, 1, 4'hF, "R5"); line(4, 8); drain();
    setcfg(4'd12, 0, 0, 4'hF, "R6"); line(2, 1); drain();
    setcfg(4'd12, 0, 1, 4'hF, "R6"); line(2, 3); drain();
    setcfg(4'd0,  0, 1, 4'hF, "R6"); line(2, 5); drain();

    setcfg(4'd9,  1, 0, 4'h5, "R7"); line(7, 3); drain();
    setcfg(4'd14, 1, 0, 4'hA, "R7"); line(3, 4); drain();

    setcfg(4'd1, 1, 0, 4'hF, "R8"); line(1, 2); drain();
    setcfg(4'd9, 1, 0, 4'hF, "R8"); line(1, 3); drain();
    line(2, 4); drain();
    line(3, 5); drain();
    line(5, 6); drain();

    bp_on = 1'b1;
    setcfg(4'd9,  1, 0, 4'hF, "R10"); line(20, 7); drain();
    setcfg(4'd15, 1, 1, 4'hF, "R10"); line(10, 8); drain();
    bp_on = 1'b0;

    setcfg(4'd5, 1, 0, 4'hF, "R9");
    line(3, 9); drain();
    check("R9 error set", 32'(fmt_err), 1);
    setcfg(4'd13, 1, 0, 4'hF, "R9");
    line(2, 1); drain();
    check("R9 error sticky", 32'(fmt_err), 1);
    setcfg(4'd10, 1, 0, 4'hF, "R9");
    line(2, 2); drain();
    check("R9 no words", 32'(expq.size()), 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 cleared by reset", 32'(fmt_err), 0);
    check("R11 idle after reset", 32'(out_valid), 0);

    check("R8 queue empty at end", 32'(expq.size()), 0);
    finish_run();
  end
endmodule